// File: doc/BRIEF.md
# Latched interrupt status controller

This block gathers single-cycle or level event inputs into sticky status bits, grouped into byte-wide status registers, and folds the enabled bits into one active-low interrupt pin. A host reaches the status, enable and control registers through a simple synchronous register port: one access per cycle, with read data registered and returned on the following cycle.

A global control register picks two policies at once. The clear policy decides whether sticky bits are cleared by reading them or only by writing a 1 to their position. The pin policy decides whether the inactive interrupt pin floats or drives high. The pin is presented as a data output plus an active-high output enable, so that a pad cell or a bench can build either an open-drain or a push-pull line.

Top module: `irq_latch_ctrl`

## Requirements
- R1: During and after reset, all status bits, all enable bits and both control bits are 0, `irq_oe_o` is 0, `irq_o` is 1 and `rdata_o` is 0.
- R2: An event bit high in a cycle sets its status bit at that clock edge. The bit stays set until a clear permitted by R3 or R5.
- R3: With the clear-mode bit (control bit 0) at 0, a read of a status register returns its value on `rdata_o` in the next cycle and clears exactly the bits returned. An event arriving in the same cycle as the read leaves its bit set.
- R4: With the clear-mode bit at 0, writes to a status register have no effect.
- R5: With the clear-mode bit at 1, a write to a status register clears each bit whose write-data bit is 1 and keeps the others. Reads do not clear.
- R6: With the clear-mode bit at 1, an event arriving in the same cycle as a write-1 clear of its bit leaves the bit set.
- R7: While any status bit is set and its matching enable bit is 1, the interrupt is active: `irq_oe_o` = 1 and `irq_o` = 0.
- R8: While the interrupt is inactive, `irq_o` = 1 and `irq_oe_o` equals the pin-mode bit (control bit 1): 0 floats the pin, 1 drives it high.
- R9: Address map: status register k is at 0x00+k, enable register k is at 0x10+k, and the control register is at 0x1E with pin mode in bit 1 and clear mode in bit 0. Other control bits and unmapped addresses read 0. `rdata_o` is 0 in any cycle that follows a cycle without a read.
- R10: An enable register returns on read the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_REGS*DW | Event inputs; bit k*DW+j feeds bit j of status register k |
| cs_i | input | 1 | Register access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid in the cycle after a read |
| irq_o | output | 1 | Interrupt pin data (0 when active) |
| irq_oe_o | output | 1 | Interrupt pin output enable, active high |

## Verification
A status bit that is lost or kept wrongly shows at the pin as soon as its enable is set: the pin drive and level follow the status register in the same cycle it changes, with no extra pipeline stage. A bit cleared when it should have stayed set shows on the next read, one cycle after the access, as a missing bit in `rdata_o`, and also as a pin that goes inactive early. A wrong control state shows either as a pin that floats when it should drive high, or as a read that clears when it should not. A reference model that runs beside the block and is compared every cycle catches each of these within one cycle of the access that exposes it.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int STAT_BASE = 'h00;
  localparam int EN_BASE   = 'h10;
  localparam int CTRL_ADDR = 'h1E;

  typedef struct packed {
    logic pin_push;  // bit 1: inactive pin drives high
    logic w1c;       // bit 0: write-1-to-clear instead of clear-on-read
  } ctrl_t;
endpackage

// File: rtl/irq_stat_reg.sv
module irq_stat_reg #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] evt_i,
  input  logic          rd_clr_i,
  input  logic          wr_clr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    if (rd_clr_i)      clr_mask = q_o;      // only bits returned to the host
    else if (wr_clr_i) clr_mask = wdata_i;
  end

  // set dominates clear so no event is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_mask) | evt_i;
  end
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv (
  input  logic active_i,
  input  logic pin_push_i,
  output logic irq_o,
  output logic irq_oe_o
);
  always_comb begin
    irq_o    = !active_i;
    irq_oe_o = active_i || pin_push_i;
  end
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int NUM_REGS = 2,
  parameter int DW       = 8,
  parameter int AW       = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_REGS*DW-1:0] evt_i,
  input  logic                   cs_i,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic                   irq_o,
  output logic                   irq_oe_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t                         ctrl_q;
  logic [NUM_REGS-1:0][DW-1:0]   stat_q;
  logic [NUM_REGS-1:0][DW-1:0]   en_q;
  logic [NUM_REGS-1:0]           stat_hit, en_hit;
  logic                          ctrl_hit;
  logic [31:0]                   a32;
  logic                          active;
  logic [DW-1:0]                 rd_mux;

  assign a32      = 32'(addr_i);
  assign ctrl_hit = cs_i && (a32 == 32'(CTRL_ADDR));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign stat_hit[g] = cs_i && (a32 == 32'(STAT_BASE + g));
    assign en_hit[g]   = cs_i && (a32 == 32'(EN_BASE + g));

    irq_stat_reg #(.DW(DW)) u_stat (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_i[g*DW +: DW]),
      .rd_clr_i (stat_hit[g] && !we_i && !ctrl_q.w1c),
      .wr_clr_i (stat_hit[g] &&  we_i &&  ctrl_q.w1c),
      .wdata_i  (wdata_i),
      .q_o      (stat_q[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                en_q[g] <= '0;
      else if (en_hit[g] && we_i) en_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ctrl_q <= '0;
    else if (ctrl_hit && we_i)  ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  always_comb begin
    active = 1'b0;
    rd_mux = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      active = active | (|(stat_q[k] & en_q[k]));
      if (stat_hit[k]) rd_mux = stat_q[k];
      if (en_hit[k])   rd_mux = en_q[k];
    end
    if (ctrl_hit) rd_mux = DW'(ctrl_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rdata_o <= '0;
    else if (cs_i && !we_i) rdata_o <= rd_mux;
    else                    rdata_o <= '0;
  end

  irq_pin_drv u_pin (
    .active_i   (active),
    .pin_push_i (ctrl_q.pin_push),
    .irq_o      (irq_o),
    .irq_oe_o   (irq_oe_o)
  );
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk #(
  parameter int NUM_REGS = 2,
  parameter int DW       = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cs_i,
  input logic                   we_i,
  input logic [NUM_REGS*DW-1:0] evt_i,
  input logic [NUM_REGS*DW-1:0] stat_i,
  input logic [NUM_REGS*DW-1:0] en_i,
  input logic                   w1c_i,
  input logic                   pin_push_i,
  input logic                   irq_o,
  input logic                   irq_oe_o
);
  p_evt_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((stat_i & $past(evt_i)) == $past(evt_i)));

  p_sticky_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> ((stat_i & $past(stat_i)) == $past(stat_i)));

  p_ignore_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && !w1c_i) |=> ((stat_i & $past(stat_i)) == $past(stat_i)));

  p_read_keeps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !we_i && w1c_i) |=> ((stat_i & $past(stat_i)) == $past(stat_i)));

  p_drive_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stat_i & en_i)) |-> (irq_oe_o && !irq_o));

  p_idle_pin_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(stat_i & en_i)) |-> (irq_o && (irq_oe_o == pin_push_i)));
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(.NUM_REGS(NUM_REGS), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_i       (cs_i),
  .we_i       (we_i),
  .evt_i      (evt_i),
  .stat_i     (stat_q),
  .en_i       (en_q),
  .w1c_i      (ctrl_q.w1c),
  .pin_push_i (ctrl_q.pin_push),
  .irq_o      (irq_o),
  .irq_oe_o   (irq_oe_o)
);

// File: tb/irq_latch_ctrl_test.sv
module irq_latch_ctrl_test;
  localparam int NR = 2;
  localparam int DW = 8;
  localparam int AW = 5;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [NR*DW-1:0] evt = '0;
  logic             cs = 1'b0, we = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic [DW-1:0]    wdata = '0;
  logic [DW-1:0]    rdata;
  logic             irq, irq_oe;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  int stat_m [NR];
  int en_m   [NR];
  int ctrl_m = 0;
  int rd_m   = 0;

  always #2.5 clk = ~clk;

  irq_latch_ctrl #(.NUM_REGS(NR), .DW(DW), .AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt), .cs_i(cs), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .irq_oe_o(irq_oe)
  );

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int a = int'(addr);
    int rd_n = 0;
    if (cs && !we) begin
      if (a < NR)                     rd_n = stat_m[a];
      else if (a >= 16 && a < 16+NR)  rd_n = en_m[a-16];
      else if (a == 30)               rd_n = ctrl_m;
    end
    if (cs && we) begin
      if (a < NR && ctrl_m[0])        stat_m[a] = stat_m[a] & ~int'(wdata);
      else if (a >= 16 && a < 16+NR)  en_m[a-16] = int'(wdata);
      else if (a == 30)               ctrl_m = int'(wdata) & 3;
    end else if (cs && a < NR && !ctrl_m[0]) begin
      stat_m[a] = 0;
    end
    for (int k = 0; k < NR; k++) stat_m[k] = stat_m[k] | int'(evt[k*DW +: DW]);
    rd_m = rd_n;
  endtask

  task automatic compare_outputs();
    bit act_m = 0;
    for (int k = 0; k < NR; k++) if ((stat_m[k] & en_m[k]) != 0) act_m = 1;
    check(cur_req, "irq_o", int'(irq), act_m ? 0 : 1);
    check(cur_req, "irq_oe_o", int'(irq_oe), (act_m || ctrl_m[1]) ? 1 : 0);
    check(cur_req, "rdata_o", int'(rdata), rd_m);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_outputs();
    cs = 1'b0; we = 1'b0; evt = '0; wdata = '0; addr = '0;
  endtask

  task automatic wr(int a, int d, logic [NR*DW-1:0] e = '0);
    cs = 1'b1; we = 1'b1; addr = AW'(a); wdata = DW'(d); evt = e; step();
  endtask

  task automatic rd(int a, logic [NR*DW-1:0] e = '0);
    cs = 1'b1; we = 1'b0; addr = AW'(a); evt = e; step();
  endtask

  task automatic idle(logic [NR*DW-1:0] e = '0);
    evt = e; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NR; k++) begin stat_m[k] = 0; en_m[k] = 0; end
    // R1: outputs held in reset
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1", "irq_oe_o in reset", int'(irq_oe), 0);
    check("R1", "irq_o in reset", int'(irq), 1);
    check("R1", "rdata_o in reset", int'(rdata), 0);
    rst_ni = 1'b1;
    idle();
    rd(0); rd(1); rd('h10); rd('h11); rd('h1E); idle();

    // R9 and R10: map, enable and control readback
    cur_req = "R10";
    wr('h10, 'hA5); wr('h11, 'h3C); rd('h10); rd('h11); idle();
    cur_req = "R9";
    wr('h1E, 'hFC); rd('h1E); rd('h1F); rd('h05); idle();
    wr('h1E, 0); wr('h10, 0); wr('h11, 0);

    // R2 and R3: latch then clear on read
    cur_req = "R2";
    idle(16'h0081); idle(); idle(16'h4000); idle(); idle();
    cur_req = "R3";
    rd(0); rd(0); rd(1, 16'h0100); rd(1); rd(1); idle();

    // R4: writes ignored in clear-on-read mode
    cur_req = "R4";
    idle(16'h0F0F); wr(0, 'hFF); wr(1, 'hFF); rd(0); rd(1); idle();

    // R5 and R6: write-1-to-clear
    cur_req = "R5";
    wr('h1E, 1); idle(16'hF0F0); rd(0); rd(0); rd(1);
    wr(0, 'h30); rd(0); wr(1, 'hF0); rd(1);
    cur_req = "R6";
    wr(0, 'hC0, 16'h0040); rd(0); wr(0, 'hFF); rd(0); idle();

    // R7 and R8: pin drive in both inactive modes
    cur_req = "R8";
    wr('h1E, 3); idle(); wr('h1E, 1); idle();
    cur_req = "R7";
    wr('h11, 'h02); idle(16'h0200); idle(); idle(16'h0004); idle();
    wr(1, 'h02); idle(); wr('h1E, 2); idle();
    rd(0); rd(1); idle();
    cur_req = "R8";
    idle(); wr('h1E, 0); idle(); wr('h11, 0); wr('h10, 0);

    // mixed traffic: R2 R3 R5 R6 R7 R8 R9 together
    cur_req = "R9 mixed";
    for (int i = 0; i < 800; i++) begin
      int pick = $urandom_range(0, 6);
      int a;
      case (pick)
        0: a = 0;  1: a = 1;  2: a = 'h10; 3: a = 'h11;
        4: a = 'h1E; 5: a = 0; default: a = $urandom_range(0, 31);
      endcase
      cs    = ($urandom_range(0, 2) != 0);
      we    = $urandom_range(0, 1);
      addr  = AW'(a);
      wdata = DW'($urandom);
      evt   = ($urandom_range(0, 3) == 0) ? (NR*DW)'($urandom) & (NR*DW)'($urandom) : '0;
      step();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule